// File: doc/BRIEF.md
# Multi-Mode Pulse Counter with Compare Interrupt

This block counts pulses arriving on two external input lines and keeps a 32-bit count value. Both lines are first brought into the system clock domain. Edges are then found on the resynchronised copies. A decoder turns those edges into single up or down steps. It has four decoding styles:

- a 4x quadrature decoder;
- a pulse line paired with a direction line;
- one line that counts up paired with one line that counts down;
- a mode that only counts up.

The count either saturates at the ends of the 32-bit range and raises sticky overflow or underflow flags, or wraps around at a programmable ring maximum. A preset port loads a new count at any time.

A compare stage gives a one-cycle interrupt pulse. It fires either when the count reaches a target value, or when the count enters a window bounded by a lower and an upper value. It fires again only after the count has left and come back. Software sets up the block through a small write-only register port with four registers.

Top module: `pulse_count_unit`

## Requirements
- R1: After reset, `count` is 0 and `overflow`, `underflow` and `irq` are all 0. The control register resets to 0 (quadrature, linear, target style, compare disabled).
- R2: An input edge changes `count` on the third rising clock edge after the input changes, and not on the second.
- R3: In quadrature mode (mode code 0), every edge on either line is one step. From a rest state of both lines low, the order A rises, B rises, A falls, B falls counts up by 4. The reverse order counts down by 4. A cycle in which both lines change at once does not change the count.
- R4: In pulse-plus-direction mode (mode code 1), each rising edge of A is one step: up when B is low, down when B is high. Falling edges of A and any change of B alone leave the count unchanged.
- R5: In up/down pair mode (mode code 2), a rising edge of A counts up and a rising edge of B counts down. Rising edges on both lines in the same cycle leave the count unchanged.
- R6: In increment mode (mode code 3), each rising edge of A counts up by one, and B has no effect.
- R7: With ring disabled (control bit 2 = 0), an up step at 0xFFFFFFFF keeps the count and sets `overflow`. A down step at 0 keeps the count and sets `underflow`. Both flags stay set until a preset load.
- R8: With ring enabled (control bit 2 = 1), an up step at the ring maximum gives 0, and a down step at 0 gives the ring maximum.
- R9: When `preset_load` is high, the next count is `preset_value`, even if a step is pending in that cycle. The load also clears both flags.
- R10: In target style (control bit 3 = 0, enable bit 4 = 1), `irq` is high for exactly one cycle when the count becomes equal to the target. It stays low while the count remains equal.
- R11: In range style (control bit 3 = 1, enable bit 4 = 1), `irq` pulses once when the count enters lower <= count <= upper. It does not pulse again until the count has left the window and re-entered it.
- R12: A write with `cfg_we` high stores `cfg_wdata` at `cfg_addr`. The addresses are: 0 = control (bits 1:0 mode, bit 2 ring, bit 3 range style, bit 4 compare enable), 1 = ring maximum, 2 = target / lower bound, 3 = upper bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_a | input | 1 | Asynchronous count line A |
| in_b | input | 1 | Asynchronous count line B |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| preset_load | input | 1 | Load `preset_value` into the count |
| preset_value | input | 32 | Value loaded into the count |
| count | output | 32 | Current count value |
| overflow | output | 1 | Sticky flag: up step refused at the top |
| underflow | output | 1 | Sticky flag: down step refused at zero |
| irq | output | 1 | One-cycle compare interrupt pulse |

## Verification
The hardest situation to reach is a preset load that lands in the same clock cycle as a decoded step. The step only exists for one cycle, deep behind the synchroniser.

The stimulus raises line A, counts exactly two rising clock edges so that the edge is pending in the decoder, and then raises `preset_load` for the third edge. The count must then show the preset value and never the preset value plus one.

Saturation at 0xFFFFFFFF and the range re-arm are reached by presetting the count next to the boundary rather than by stepping there.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

    localparam int CNT_W = 32;

    typedef enum logic [1:0] {
        MODE_QUAD = 2'd0,
        MODE_PDIR = 2'd1,
        MODE_UPDN = 2'd2,
        MODE_INCR = 2'd3
    } in_mode_e;

    typedef struct packed {
        in_mode_e           mode;
        logic               ring_en;
        logic               range_en;
        logic               cmp_en;
        logic [CNT_W-1:0]   ring_max;
        logic [CNT_W-1:0]   cmp_lo;
        logic [CNT_W-1:0]   cmp_hi;
    } cfg_t;

endpackage

// File: rtl/hsc_edge_sync.sv
module hsc_edge_sync #(
    parameter int N_IN   = 2,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] raw,
    output logic [N_IN-1:0] lvl,
    output logic [N_IN-1:0] tog
);

    genvar gi;
    generate
        for (gi = 0; gi < N_IN; gi++) begin : g_line
            // STAGES synchroniser flops plus one history flop for edge detection
            logic [STAGES:0] sh_d, sh_q;

            always_comb begin
                sh_d = {sh_q[STAGES-1:0], raw[gi]};
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= sh_d;
            end

            assign lvl[gi] = sh_q[STAGES-1];
            assign tog[gi] = sh_q[STAGES-1] ^ sh_q[STAGES];
        end
    endgenerate

endmodule

// File: rtl/hsc_decode.sv
module hsc_decode
    import hsc_pkg::*;
(
    input  in_mode_e   mode,
    input  logic [1:0] lvl,   // [0] = A, [1] = B
    input  logic [1:0] tog,
    output logic       up,
    output logic       dn
);

    logic rise_a, rise_b;

    always_comb begin
        rise_a = tog[0] & lvl[0];
        rise_b = tog[1] & lvl[1];
        up = 1'b0;
        dn = 1'b0;
        unique case (mode)
            MODE_QUAD: begin
                // a single line moving is a valid step; both together is invalid
                if (tog[0] && !tog[1]) begin
                    up = lvl[0] ^ lvl[1];
                    dn = ~(lvl[0] ^ lvl[1]);
                end else if (tog[1] && !tog[0]) begin
                    up = ~(lvl[0] ^ lvl[1]);
                    dn = lvl[0] ^ lvl[1];
                end
            end
            MODE_PDIR: begin
                up = rise_a & ~lvl[1];
                dn = rise_a & lvl[1];
            end
            MODE_UPDN: begin
                up = rise_a & ~rise_b;
                dn = rise_b & ~rise_a;
            end
            MODE_INCR: begin
                up = rise_a;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/hsc_core.sv
module hsc_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up,
    input  logic         dn,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         ring_en,
    input  logic [W-1:0] ring_max,
    output logic [W-1:0] cnt,
    output logic         ovf,
    output logic         udf
);

    localparam logic [W-1:0] CNT_TOP = '1;
    localparam logic [W-1:0] ONE     = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         ovf;
        logic         udf;
    } core_t;

    core_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
            st_d.ovf = 1'b0;
            st_d.udf = 1'b0;
        end else if (up) begin
            if (ring_en)
                st_d.cnt = (st_q.cnt >= ring_max) ? '0 : st_q.cnt + ONE;
            else if (st_q.cnt == CNT_TOP)
                st_d.ovf = 1'b1;
            else
                st_d.cnt = st_q.cnt + ONE;
        end else if (dn) begin
            if (ring_en)
                st_d.cnt = (st_q.cnt == '0 || st_q.cnt > ring_max) ? ring_max : st_q.cnt - ONE;
            else if (st_q.cnt == '0)
                st_d.udf = 1'b1;
            else
                st_d.cnt = st_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign ovf = st_q.ovf;
    assign udf = st_q.udf;

    a_r7_hold_top: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && up && !ring_en && cnt == CNT_TOP) |=> (cnt == CNT_TOP && ovf));
    a_r7_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && dn && !up && !ring_en && cnt == '0) |=> (cnt == '0 && udf));
    a_r7_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && (ovf || udf)) |=> ((ovf || !$past(ovf)) && (udf || !$past(udf))));
    a_r8_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && up && ring_en && cnt == ring_max) |=> (cnt == '0));
    a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val) && !ovf && !udf));

endmodule

// File: rtl/hsc_compare.sv
module hsc_compare #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    input  logic         en,
    input  logic         range_en,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         irq
);

    typedef struct packed {
        logic zone;
        logic irq;
    } cmp_t;

    cmp_t cs_d, cs_q;
    logic hit;

    always_comb begin
        if (range_en) hit = (cnt >= lo) && (cnt <= hi);
        else          hit = (cnt == lo);
        hit     = hit & en;
        cs_d.zone = hit;
        cs_d.irq  = hit & ~cs_q.zone;   // fire only on entry
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign irq = cs_q.irq;

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    a_r11_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $stable(cnt) && $stable(lo) && $stable(hi)) |=> !irq);

endmodule

// File: rtl/pulse_count_unit.sv
module pulse_count_unit
    import hsc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_a,
    input  logic             in_b,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    input  logic             preset_load,
    input  logic [31:0]      preset_value,
    output logic [31:0]      count,
    output logic             overflow,
    output logic             underflow,
    output logic             irq
);

    localparam int W = CNT_W;

    cfg_t       cfg_d, cfg_q;
    logic [1:0] lvl, tog;
    logic       step_up, step_dn;

    // configuration registers
    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            unique case (cfg_addr)
                2'd0: begin
                    cfg_d.mode     = in_mode_e'(cfg_wdata[1:0]);
                    cfg_d.ring_en  = cfg_wdata[2];
                    cfg_d.range_en = cfg_wdata[3];
                    cfg_d.cmp_en   = cfg_wdata[4];
                end
                2'd1: cfg_d.ring_max = cfg_wdata;
                2'd2: cfg_d.cmp_lo   = cfg_wdata;
                2'd3: cfg_d.cmp_hi   = cfg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q          <= '0;
            cfg_q.ring_max <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    hsc_edge_sync #(.N_IN(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({in_b, in_a}),
        .lvl   (lvl),
        .tog   (tog)
    );

    hsc_decode u_dec (
        .mode  (cfg_q.mode),
        .lvl   (lvl),
        .tog   (tog),
        .up    (step_up),
        .dn    (step_dn)
    );

    a_r5_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up && step_dn));
    a_r3_quad_double_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode == MODE_QUAD && tog == 2'b11) |-> !(step_up || step_dn));
    a_r6_incr_never_down: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode == MODE_INCR) |-> !step_dn);

    hsc_core #(.W(W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .up       (step_up),
        .dn       (step_dn),
        .load     (preset_load),
        .load_val (preset_value),
        .ring_en  (cfg_q.ring_en),
        .ring_max (cfg_q.ring_max),
        .cnt      (count),
        .ovf      (overflow),
        .udf      (underflow)
    );

    hsc_compare #(.W(W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (count),
        .en       (cfg_q.cmp_en),
        .range_en (cfg_q.range_en),
        .lo       (cfg_q.cmp_lo),
        .hi       (cfg_q.cmp_hi),
        .irq      (irq)
    );

endmodule

// File: tb/sim_pulse_count_unit.sv
module sim_pulse_count_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_a = 1'b0, in_b = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        preset_load = 1'b0;
    logic [31:0] preset_value = '0;
    logic [31:0] count;
    logic        overflow, underflow, irq;

    int n_chk = 0, n_bad = 0, irq_seen = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pulse_count_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .preset_load(preset_load), .preset_value(preset_value),
        .count(count), .overflow(overflow), .underflow(underflow), .irq(irq)
    );

    always @(negedge clk) if (rst_n && irq) irq_seen++;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic preset(input logic [31:0] v);
        preset_load = 1'b1; preset_value = v;
        @(negedge clk);
        preset_load = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic drive(input logic a, input logic b);
        in_a = a; in_b = b;
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse_a(input logic b);
        drive(1'b1, b); drive(1'b0, b);
    endtask

    task automatic pulse_b();
        drive(1'b0, 1'b1); drive(1'b0, 1'b0);
    endtask

    task automatic t_reset();
        check(count == 0, "R1 count", count, 0);
        check({overflow, underflow, irq} == 3'b000, "R1 flags", {29'd0, overflow, underflow, irq}, 0);
    endtask

    task automatic t_latency();
        cfg(2'd0, 32'd3);
        preset(32'd0);
        in_a = 1'b1;
        repeat (2) @(negedge clk);
        check(count == 0, "R2 not yet after two edges", count, 0);
        @(negedge clk);
        check(count == 1, "R2 step on third edge", count, 1);
        drive(1'b0, 1'b0);
    endtask

    task automatic t_incr();
        cfg(2'd0, 32'd3);
        preset(32'd40);
        pulse_a(1'b0); pulse_a(1'b0);
        check(count == 42, "R6 two A pulses", count, 42);
        pulse_b(); pulse_b();
        check(count == 42, "R6 B ignored", count, 42);
    endtask

    task automatic t_quad();
        cfg(2'd0, 32'd0);
        preset(32'd100);
        drive(1, 0); drive(1, 1); drive(0, 1); drive(0, 0);
        check(count == 104, "R3 A leads: +4", count, 104);
        drive(0, 1); drive(1, 1); drive(1, 0); drive(0, 0);
        check(count == 100, "R3 B leads: -4", count, 100);
        drive(1, 1);
        check(count == 100, "R3 both lines change", count, 100);
        drive(0, 0);
        check(count == 100, "R3 both lines return", count, 100);
    endtask

    task automatic t_pdir();
        cfg(2'd0, 32'd1);
        preset(32'd50);
        pulse_a(1'b0); pulse_a(1'b0); pulse_a(1'b0);
        check(count == 53, "R4 up with B low", count, 53);
        drive(1'b0, 1'b1);
        check(count == 53, "R4 B change alone", count, 53);
        pulse_a(1'b1); pulse_a(1'b1);
        check(count == 51, "R4 down with B high", count, 51);
        drive(1'b0, 1'b0);
    endtask

    task automatic t_updn();
        cfg(2'd0, 32'd2);
        preset(32'd10);
        pulse_a(1'b0); pulse_a(1'b0);
        check(count == 12, "R5 A up", count, 12);
        pulse_b();
        check(count == 11, "R5 B down", count, 11);
        drive(1'b1, 1'b1); drive(1'b0, 1'b0);
        check(count == 11, "R5 simultaneous rise", count, 11);
    endtask

    task automatic t_linear();
        cfg(2'd0, 32'd3);
        preset(32'hFFFF_FFFE);
        pulse_a(1'b0);
        check(count == 32'hFFFF_FFFF && !overflow, "R7 reach top, no flag", count, 32'hFFFF_FFFF);
        pulse_a(1'b0);
        check(count == 32'hFFFF_FFFF, "R7 hold at top", count, 32'hFFFF_FFFF);
        check(overflow == 1'b1, "R7 overflow set", {31'd0, overflow}, 1);
        preset(32'd5);
        check(overflow == 1'b0 && count == 5, "R9 preset clears overflow", {31'd0, overflow}, 0);
        cfg(2'd0, 32'd2);
        preset(32'd1);
        pulse_b();
        check(count == 0 && !underflow, "R7 reach zero, no flag", count, 0);
        pulse_b();
        check(count == 0 && underflow, "R7 hold at zero with underflow", {31'd0, underflow}, 1);
        pulse_a(1'b0);
        check(underflow == 1'b1, "R7 underflow sticky", {31'd0, underflow}, 1);
    endtask

    task automatic t_ring();
        cfg(2'd1, 32'd5);
        cfg(2'd0, 32'd6);
        preset(32'd4);
        pulse_a(1'b0);
        check(count == 5, "R12 ring max register", count, 5);
        pulse_a(1'b0);
        check(count == 0, "R8 wrap up to zero", count, 0);
        pulse_b();
        check(count == 5, "R8 wrap down to max", count, 5);
        cfg(2'd0, 32'd2);
    endtask

    task automatic t_preset_race();
        cfg(2'd0, 32'd3);
        preset(32'd7);
        in_a = 1'b1;
        repeat (2) @(negedge clk);
        preset_load = 1'b1; preset_value = 32'd1000;
        @(negedge clk);
        preset_load = 1'b0;
        repeat (4) @(negedge clk);
        check(count == 1000, "R9 load beats pending step", count, 1000);
        drive(1'b0, 1'b0);
    endtask

    task automatic t_target();
        cfg(2'd2, 32'd20);
        cfg(2'd0, 32'd19);
        preset(32'd18);
        repeat (3) @(negedge clk);
        irq_seen = 0;
        pulse_a(1'b0);
        check(irq_seen == 0, "R10 no irq at 19", irq_seen, 0);
        pulse_a(1'b0);
        check(irq_seen == 1, "R10 one irq at target", irq_seen, 1);
        repeat (10) @(negedge clk);
        check(irq_seen == 1, "R10 no repeat while equal", irq_seen, 1);
    endtask

    task automatic t_range();
        cfg(2'd0, 32'd2);
        cfg(2'd2, 32'd30);
        cfg(2'd3, 32'd32);
        preset(32'd28);
        cfg(2'd0, 32'd26);
        repeat (3) @(negedge clk);
        irq_seen = 0;
        pulse_a(1'b0);
        check(irq_seen == 0, "R11 below window", irq_seen, 0);
        pulse_a(1'b0);
        check(irq_seen == 1, "R11 entry at lower bound", irq_seen, 1);
        pulse_a(1'b0); pulse_a(1'b0);
        check(irq_seen == 1, "R11 moving inside window", irq_seen, 1);
        pulse_a(1'b0);
        check(count == 33 && irq_seen == 1, "R11 left window", count, 33);
        pulse_b();
        check(irq_seen == 2, "R11 re-entry from above", irq_seen, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_incr();
        t_quad();
        t_pdir();
        t_updn();
        t_linear();
        t_ring();
        t_preset_race();
        t_target();
        t_range();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R1-watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule